// File: doc/BRIEF.md
# Dual-Processor Doorbell Mailbox

This block lets two processors ring each other's doorbells. Each processor owns a 4-bit status word held inside the block. Either processor may raise bits in a status word through a write-one-to-set register, or drop bits through a write-one-to-clear register. The status word itself is read-only. Whenever a status word is non-zero, the level interrupt line of its processor is high. Software on the receiving side reads its status, handles the events, and clears the bits it has handled.

Access is through a 32-bit APB-style slave that decodes a 4 KB window. Only full, word-aligned 32-bit transfers are meaningful. Every transfer completes with no wait states and never reports an error. The upper part of the window holds twelve read-only identification words, one byte per word.

The bus is the only data path into or out of the block. It completes in the access phase, so the block applies no back-pressure. The interrupt lines are plain level outputs with no handshake.

Top module: `dbell_mailbox`

## Requirements
- R1: After reset both status words read 0 and both `irq_p0` and `irq_p1` are low.
- R2: A write to offset 0x004 (processor 0) or 0x014 (processor 1) ORs `pwdata[3:0]` into that processor's status. Bits 31:4 of the write data are ignored.
- R3: A write to offset 0x008 (processor 0) or 0x018 (processor 1) clears, in that processor's status, every bit set in `pwdata[3:0]`. Bits 31:4 of the write data are ignored.
- R4: `irq_pN` is high exactly when status N is non-zero. It changes on the clock edge that completes the write changing the status.
- R5: A read of offset 0x000 (processor 0) or 0x010 (processor 1) returns that status in bits 3:0, with bits 31:4 zero.
- R6: A read of any set or clear register returns zero.
- R7: Reads of the word offsets 0xFD0 to 0xFFC, in ascending order, return 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R8: Writes to a status offset or to an identification offset change no state.
- R9: A read of any other offset returns zero, and a write to it changes no state. Any offset with `paddr[1:0]` non-zero counts as unmapped.
- R10: A write to one processor's set or clear register leaves the other processor's status and interrupt unchanged.
- R11: `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Error response (always 0) |
| irq_p0 | output | 1 | Level interrupt for processor 0 |
| irq_p1 | output | 1 | Level interrupt for processor 1 |

## Verification
The set and clear registers are exercised with several kinds of write data:
- Single bits, to show that a set ORs into the status and does not overwrite it.
- Data with bits above bit 3, to expose a missing mask.
- Clears of bits that are not set, to show that a clear only removes bits.
- An all-ones clear, which drops the interrupt.

The two processors are interleaved to separate a correct processor select from a shared or crossed status word. Writes to read-only, unmapped and misaligned offsets are followed by reads of both status words, so that a write which lands anywhere shows up at the ports. A reference model in the bench tracks both status words and checks both interrupt lines on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int STAT_W  = 4;
  localparam int NUM_CPU = 2;
  localparam int ID_NUM  = 12;
  localparam int ID_IDX_W = $clog2(ID_NUM);
  localparam int ID_FIRST_WORD = 'h3F4;   // word address of the first ID word

  typedef enum logic [1:0] {
    KIND_STAT = 2'd0,
    KIND_SET  = 2'd1,
    KIND_CLR  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic                is_cpu;
    logic                cpu;
    reg_kind_e           kind;
    logic                is_id;
    logic [ID_IDX_W-1:0] id_idx;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h56;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h0B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  localparam int WORD_W = AW - 2;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] id_off;
  logic              aligned;

  assign word    = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign id_off  = word - WORD_W'(ID_FIRST_WORD);

  always_comb begin
    dec        = '0;
    dec.kind   = KIND_NONE;
    dec.cpu    = addr[4];
    dec.id_idx = id_off[ID_IDX_W-1:0];
    if (aligned && (addr[AW-1:5] == '0) && (addr[3:2] != 2'b11)) begin
      dec.is_cpu = 1'b1;
      dec.kind   = reg_kind_e'(addr[3:2]);
    end
    if (aligned && (word >= WORD_W'(ID_FIRST_WORD)) &&
        (id_off < WORD_W'(ID_NUM)))
      dec.is_id = 1'b1;
  end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell
  import mbx_pkg::*;
#(
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic          clr_en,
  input  logic [SW-1:0] bits,
  output logic [SW-1:0] status,
  output logic          irq
);
  logic [SW-1:0] status_nx;

  always_comb begin
    status_nx = status;
    if (set_en) status_nx = status | bits;
    if (clr_en) status_nx = status & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      irq    <= |status_nx;
    end
  end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              irq_p0,
  output logic              irq_p1
);
  dec_t              dec;
  logic              wr_acc;
  logic [STAT_W-1:0] stat [NUM_CPU];
  logic [NUM_CPU-1:0] irq_v;
  logic              unused_wdata_hi;

  assign wr_acc          = psel & penable & pwrite;
  assign unused_wdata_hi = ^pwdata[DATA_W-1:STAT_W];

  mbx_decode #(.AW(ADDR_W)) u_dec (.addr(paddr), .dec(dec));

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    logic hit;
    assign hit = wr_acc & dec.is_cpu & (dec.cpu == g[0]);
    mbx_cell #(.SW(STAT_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (hit & (dec.kind == KIND_SET)),
      .clr_en (hit & (dec.kind == KIND_CLR)),
      .bits   (pwdata[STAT_W-1:0]),
      .status (stat[g]),
      .irq    (irq_v[g])
    );
  end

  always_comb begin
    prdata = '0;
    if (dec.is_cpu && dec.kind == KIND_STAT)
      prdata[STAT_W-1:0] = stat[dec.cpu];
    else if (dec.is_id)
      prdata[7:0] = id_byte(dec.id_idx);
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign irq_p0  = irq_v[0];
  assign irq_p1  = irq_v[1];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        pslverr,
  input logic        irq_p0,
  input logic        irq_p1
);
  logic acc;
  assign acc = psel && penable;

  assert_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  assert_set_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && paddr == 12'h004 && pwdata[3:0] != 4'h0) |=> irq_p0);

  assert_clr_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && paddr == 12'h018 && pwdata[3:0] == 4'hF) |=> !irq_p1);

  assert_other_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && paddr[11:5] == 7'd0 && !paddr[4]) |=> $stable(irq_p1));

  assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pwrite && (paddr == 12'h000 || paddr == 12'h010))
      |=> ($stable(irq_p0) && $stable(irq_p1)));

  assert_wo_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pwrite && (paddr == 12'h004 || paddr == 12'h008 ||
                        paddr == 12'h014 || paddr == 12'h018)) |-> prdata == 32'd0);

  assert_stat_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pwrite && (paddr == 12'h000 || paddr == 12'h010))
      |-> prdata[31:4] == 28'd0);
endmodule

bind dbell_mailbox mbx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
  .pslverr(pslverr), .irq_p0(irq_p0), .irq_p1(irq_p1)
);

// File: tb/dbell_mailbox_tb.sv
module dbell_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq_p0, irq_p1;

  int checks = 0, bad = 0, cycles = 0;
  int m_stat [2];
  bit finished = 0;
  int id_tab [12] = '{'h04, 'h00, 'h00, 'h00, 'h56, 'hB8, 'h0B, 'h00,
                      'h0D, 'hF0, 'h05, 'hB1};

  always #5 clk = ~clk;

  dbell_mailbox u_dut (.*);

  function automatic int exp_read(input int a);
    if (a == 'h000) return m_stat[0];
    if (a == 'h010) return m_stat[1];
    if (a >= 'hFD0 && a <= 'hFFC && (a % 4) == 0) return id_tab[(a - 'hFD0) / 4];
    return 0;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // compare outputs against the model on every clock
  always @(negedge clk) if (rst_n && !finished) begin
    check("R4 irq_p0", irq_p0, m_stat[0] != 0);
    check("R4 irq_p1", irq_p1, m_stat[1] != 0);
    check("R11 resp", {pready, pslverr}, 2'b10);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a[11:0]; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(posedge clk);
    // model: applied on the edge that completes the access
    if (a == 'h004) m_stat[0] |= d & 'hF;
    if (a == 'h008) m_stat[0] &= ~(d & 'hF);
    if (a == 'h014) m_stat[1] |= d & 'hF;
    if (a == 'h018) m_stat[1] &= ~(d & 'hF);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input string req, input int a);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = a[11:0];
    @(negedge clk);
    penable = 1;
    #1 check(req, prdata, exp_read(a));
    @(posedge clk);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic rd_both(input string req);
    rd(req, 'h000);
    rd(req, 'h010);
  endtask

  initial begin
    m_stat[0] = 0; m_stat[1] = 0;
    #1 check("R1 irq_p0 in reset", irq_p0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_both("R1 status after reset");
    check("R1 irqs after reset", {irq_p0, irq_p1}, 2'b00);

    wr('h004, 'h1);          rd_both("R2 set bit0 p0");
    wr('h004, 'h4);          rd_both("R2 set ORs p0");
    wr('h004, 'hFFFF_FFF2);  rd_both("R2 mask on set");
    wr('h014, 'hA);          rd_both("R10 p1 set leaves p0");
    wr('h008, 'h2);          rd_both("R3 clr bit1 p0");
    wr('h008, 'h8);          rd_both("R3 clr of clear bit");
    wr('h008, 'hFFFF_FFF0);  rd_both("R3 mask on clr");
    wr('h018, 'h2);          rd_both("R10 p1 clr leaves p0");

    rd("R6 set0 reads 0", 'h004); rd("R6 clr0 reads 0", 'h008);
    rd("R6 set1 reads 0", 'h014); rd("R6 clr1 reads 0", 'h018);
    rd("R5 stat0 value", 'h000);

    wr('h000, 'hF);   wr('h010, 'h0);  rd_both("R8 status write ignored");
    wr('hFD0, 'hF);   wr('hFFC, 'h0);  rd_both("R8 id write ignored");
    wr('h00C, 'hF);   wr('h020, 'hF);  wr('h104, 'hF);
    wr('h005, 'hF);   wr('h016, 'hF);  wr('h009, 'hF);
    rd_both("R9 unmapped writes ignored");

    for (int i = 0; i < 12; i++) rd("R7 id word", 'hFD0 + 4 * i);
    rd("R9 unmapped read", 'h00C); rd("R9 unmapped read", 'h020);
    rd("R9 unmapped read", 'hFCC); rd("R9 unaligned read", 'h001);
    rd("R9 unaligned id read", 'hFD2);

    wr('h008, 'hF);  rd_both("R3 clr all p0");
    wr('h018, 'hF);  rd_both("R3 clr all p1");
    check("R4 both irqs low", {irq_p0, irq_p1}, 2'b00);

    wr('h014, 'h1);  wr('h004, 'h8);
    @(negedge clk); rst_n = 0;
    m_stat[0] = 0; m_stat[1] = 0;
    #1 check("R1 reset clears irqs", {irq_p0, irq_p1}, 2'b00);
    @(negedge clk); rst_n = 1;
    rd_both("R1 status after second reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule